// File: doc/BRIEF.md
# Exception Capture and Redirect Unit

This unit sits next to the control state machine of a multicycle processor and handles two synchronous faults. One is an opcode that matches no known instruction class, caught while the controller is in its decode step. The other is an arithmetic overflow from a register-register operation, caught while the controller is in its execute step. When a fault is accepted, the unit records a cause code and saves the address of the faulting instruction in an exception PC register. It then asks the program counter to load a fixed handler entry address, which hands control back to instruction fetch.

The unit works as a fixed three-step sequence after acceptance:
1. It writes the cause code.
2. It writes the exception PC. This value is the incremented PC, captured when the fault was accepted, minus the instruction size.
3. It raises a one-cycle PC load request that carries the handler address.

During the whole sequence the unit tells the controller to suppress the faulting instruction's register write, so the instruction leaves no architectural effect. Fault flags seen while a sequence is running, or outside their matching controller step, are ignored.

Top module: `exc_redirect_unit`

## Requirements
- R1: After reset, `cause` and `epc` are 0, and `pc_load` and `kill_wb` are 0.
- R2: `illegal_op` high while `in_decode` is high, with the unit idle, writes cause code 0 into `cause`.
- R3: `overflow` high while `in_exec_rr` is high, with the unit idle, writes cause code 1 into `cause`.
- R4: The exception PC becomes `cur_pc - 4` (modulo 2^32). Here `cur_pc` is the value present on the cycle the fault is accepted; later changes to `cur_pc` have no effect. A `cur_pc` of 0 gives 32'hFFFF_FFFC.
- R5: Exactly three cycles after acceptance, `pc_load` is high for one cycle with `pc_load_value` equal to `HANDLER_ADDR` (default 32'h8000_0180). The unit is idle on the next cycle.
- R6: `kill_wb` is high on each of the three cycles that follow the accepting edge, ending with the `pc_load` cycle, and is low otherwise.
- R7: If both fault conditions are valid on the same cycle, cause code 0 (undefined opcode) is recorded.
- R8: `illegal_op` without `in_decode`, or `overflow` without `in_exec_rr`, starts nothing. No `kill_wb`, no `pc_load`, and `cause` and `epc` stay unchanged.
- R9: Fault flags that arrive while a sequence is running are ignored. The running sequence completes once with its own cause and PC, and no second sequence follows.
- R10: The writes happen in order. `cause` changes one cycle after acceptance, `epc` changes one cycle later, and `pc_load` is seen in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | Incremented program counter from the datapath |
| in_decode | input | 1 | Controller is in its decode step |
| in_exec_rr | input | 1 | Controller is in the execute step of a register-register instruction |
| illegal_op | input | 1 | Opcode matches no known class |
| overflow | input | 1 | Arithmetic overflow from the ALU |
| epc | output | 32 | Saved address of the faulting instruction |
| cause | output | 32 | Cause code (0 undefined opcode, 1 overflow) |
| kill_wb | output | 1 | Suppress the register-file write of the faulting instruction |
| pc_load | output | 1 | Request to load the program counter |
| pc_load_value | output | 32 | Address to load (handler entry when `pc_load` is high) |

## Verification
The hardest situation to reach is a second fault condition arriving while a sequence is still running, which must not disturb the saved cause or PC. To get there, the stimulus drives random flag, controller-step and PC noise on every busy cycle. Directed cases add two more stimuli: both valid faults on the same cycle, which checks priority, and a faulting PC of 0, which checks wrap-around. Random flags raised outside their matching controller step check that they are ignored.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int DEF_ADDR_W  = 32;
    localparam int DEF_CAUSE_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAUSE = 2'd1,
        ST_EPC   = 2'd2,
        ST_LOAD  = 2'd3
    } exc_state_e;

    typedef enum logic {
        CODE_UNDEF = 1'b0,
        CODE_OVF   = 1'b1
    } exc_code_e;

    typedef struct packed {
        logic cause_we;
        logic epc_we;
        logic pc_we;
        logic kill_wb;
    } exc_ctl_t;

    // Moore decode of the sequence step into control strobes
    function automatic exc_ctl_t ctl_of(exc_state_e s);
        exc_ctl_t c;
        c = '0;
        case (s)
            ST_CAUSE: begin c.cause_we = 1'b1; c.kill_wb = 1'b1; end
            ST_EPC:   begin c.epc_we   = 1'b1; c.kill_wb = 1'b1; end
            ST_LOAD:  begin c.pc_we    = 1'b1; c.kill_wb = 1'b1; end
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/exc_seq.sv
module exc_seq
    import exc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trig_undef,
    input  logic      trig_ovf,
    output logic      accept,
    output exc_code_e code_q,
    output exc_ctl_t  ctl
);
    exc_state_e state_q, state_d;

    assign accept = (state_q == ST_IDLE) && (trig_undef || trig_ovf);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (accept) state_d = ST_CAUSE;
            ST_CAUSE: state_d = ST_EPC;
            ST_EPC:   state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= CODE_UNDEF;
        end else begin
            state_q <= state_d;
            // decode precedes execute, so the undefined opcode wins
            if (accept) code_q <= trig_undef ? CODE_UNDEF : CODE_OVF;
        end
    end

    assign ctl = ctl_of(state_q);
endmodule

// File: rtl/exc_sub.sv
module exc_sub #(
    parameter int W   = 32,
    parameter int DEC = 4
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] DEC_V = W'(DEC);
    assign y = a - DEC_V;
endmodule

// File: rtl/exc_regs.sv
module exc_regs
    import exc_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int CAUSE_W = DEF_CAUSE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [ADDR_W-1:0]  pc_in,
    input  logic               cause_we,
    input  exc_code_e          code,
    input  logic               epc_we,
    input  logic [ADDR_W-1:0]  epc_d,
    output logic [ADDR_W-1:0]  snap_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [ADDR_W-1:0]  epc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q  <= '0;
            cause_q <= '0;
            epc_q   <= '0;
        end else begin
            if (accept)   snap_q  <= pc_in;
            if (cause_we) cause_q <= CAUSE_W'(code);
            if (epc_we)   epc_q   <= epc_d;
        end
    end
endmodule

// File: rtl/exc_redirect_unit.sv
module exc_redirect_unit
    import exc_pkg::*;
#(
    parameter int                ADDR_W       = DEF_ADDR_W,
    parameter int                CAUSE_W      = DEF_CAUSE_W,
    parameter int                INSTR_BYTES  = 4,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h8000_0180
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic               in_decode,
    input  logic               in_exec_rr,
    input  logic               illegal_op,
    input  logic               overflow,
    output logic [ADDR_W-1:0]  epc,
    output logic [CAUSE_W-1:0] cause,
    output logic               kill_wb,
    output logic               pc_load,
    output logic [ADDR_W-1:0]  pc_load_value
);
    logic              accept;
    exc_code_e         code;
    exc_ctl_t          ctl;
    logic [ADDR_W-1:0] snap;
    logic [ADDR_W-1:0] epc_d;

    exc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .trig_undef (in_decode && illegal_op),
        .trig_ovf   (in_exec_rr && overflow),
        .accept     (accept),
        .code_q     (code),
        .ctl        (ctl)
    );

    exc_sub #(.W(ADDR_W), .DEC(INSTR_BYTES)) u_sub (
        .a (snap),
        .y (epc_d)
    );

    exc_regs #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .pc_in    (cur_pc),
        .cause_we (ctl.cause_we),
        .code     (code),
        .epc_we   (ctl.epc_we),
        .epc_d    (epc_d),
        .snap_q   (snap),
        .cause_q  (cause),
        .epc_q    (epc)
    );

    assign kill_wb       = ctl.kill_wb;
    assign pc_load       = ctl.pc_we;
    assign pc_load_value = ctl.pc_we ? HANDLER_ADDR : '0;
endmodule

// File: rtl/exc_redirect_unit_chk.sv
module exc_redirect_unit_chk #(
    parameter int                ADDR_W       = 32,
    parameter int                CAUSE_W      = 32,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h8000_0180
) (
    input logic               clk,
    input logic               rst,
    input logic               pc_load,
    input logic [ADDR_W-1:0]  pc_load_value,
    input logic               kill_wb,
    input logic [CAUSE_W-1:0] cause,
    input logic [ADDR_W-1:0]  epc
);
    p_load_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load);

    p_load_value_r5: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> pc_load_value == HANDLER_ADDR);

    p_kill_window_r6: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> kill_wb && $past(kill_wb, 1) && $past(kill_wb, 2));

    p_idle_after_load_r6: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !kill_wb);

    p_epc_slot_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(epc) |-> pc_load);

    p_cause_slot_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(cause) |-> kill_wb && !pc_load && $past(kill_wb));
endmodule

bind exc_redirect_unit exc_redirect_unit_chk #(
    .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .HANDLER_ADDR(HANDLER_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .pc_load(pc_load), .pc_load_value(pc_load_value),
    .kill_wb(kill_wb), .cause(cause), .epc(epc)
);

// File: tb/exc_redirect_unit_bench.sv
`timescale 1ns/1ps
module exc_redirect_unit_bench;
    localparam logic [31:0] HANDLER = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cur_pc;
    logic        in_decode, in_exec_rr, illegal_op, overflow;
    logic [31:0] epc, cause, pc_load_value;
    logic        kill_wb, pc_load;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] exp_cause = '0;
    logic [31:0] exp_epc   = '0;

    always #2.5 clk = ~clk;

    exc_redirect_unit u_exc_redirect_unit (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .in_decode(in_decode),
        .in_exec_rr(in_exec_rr), .illegal_op(illegal_op), .overflow(overflow),
        .epc(epc), .cause(cause), .kill_wb(kill_wb), .pc_load(pc_load),
        .pc_load_value(pc_load_value)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] epc_model(input logic [31:0] pc);
        return pc - 32'd4;
    endfunction

    task automatic noise();
        cur_pc     = $urandom;
        in_decode  = 1'($urandom);
        in_exec_rr = 1'($urandom);
        illegal_op = 1'($urandom);
        overflow   = 1'($urandom);
    endtask

    task automatic quiet();
        in_decode = 0; in_exec_rr = 0; illegal_op = 0; overflow = 0;
    endtask

    task automatic episode(input logic [31:0] pc, input bit dec, input bit exe,
                           input bit ill, input bit ovf, input bit busy_noise);
        bit t_und, t_ovf;
        logic [31:0] old_cause, old_epc, new_cause;
        @(negedge clk);
        cur_pc = pc; in_decode = dec; in_exec_rr = exe;
        illegal_op = ill; overflow = ovf;
        t_und = dec && ill;
        t_ovf = exe && ovf;
        old_cause = exp_cause; old_epc = exp_epc;
        @(negedge clk);
        if (!(t_und || t_ovf)) begin
            chk(!kill_wb && !pc_load, "R8 no sequence", {30'b0, kill_wb, pc_load}, 32'h0);
            chk(cause == old_cause, "R8 cause kept", cause, old_cause);
            chk(epc == old_epc, "R8 epc kept", epc, old_epc);
            quiet();
            return;
        end
        new_cause = t_und ? 32'd0 : 32'd1;  // R2 / R3 / R7 priority
        exp_cause = new_cause;
        exp_epc   = epc_model(pc);
        if (busy_noise) noise(); else quiet();
        chk(kill_wb && !pc_load, "R6 kill step1", {30'b0, kill_wb, pc_load}, 32'h2);
        chk(cause == old_cause, "R10 cause not yet", cause, old_cause);
        @(negedge clk);
        if (busy_noise) noise();
        chk(cause == new_cause, t_und ? (t_ovf ? "R7 priority" : "R2 undef code")
                                      : "R3 overflow code", cause, new_cause);
        chk(epc == old_epc, "R10 epc not yet", epc, old_epc);
        chk(kill_wb && !pc_load, "R6 kill step2", {30'b0, kill_wb, pc_load}, 32'h2);
        @(negedge clk);
        if (busy_noise) noise();
        chk(epc == exp_epc, "R4 epc value", epc, exp_epc);
        chk(pc_load && kill_wb, "R5 load asserted", {30'b0, kill_wb, pc_load}, 32'h3);
        chk(pc_load_value == HANDLER, "R5 handler value", pc_load_value, HANDLER);
        @(negedge clk);
        chk(!pc_load && !kill_wb, "R5 idle after load", {30'b0, kill_wb, pc_load}, 32'h0);
        chk(cause == new_cause && epc == exp_epc, "R9 busy flags ignored", epc, exp_epc);
        quiet();
    endtask

    initial begin
        rst = 1'b1; cur_pc = '0; quiet();
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk(cause == 0 && epc == 0, "R1 regs reset", epc, 32'h0);
        chk(!pc_load && !kill_wb, "R1 strobes reset", {30'b0, kill_wb, pc_load}, 32'h0);
        rst = 1'b0;
        // directed corner cases
        episode(32'h0000_1004, 0, 1, 0, 1, 0);   // R3 overflow
        episode(32'h0000_2008, 1, 0, 1, 0, 0);   // R2 undef after code 1
        episode(32'h0000_0000, 0, 1, 0, 1, 0);   // R4 wrap-around
        episode(32'h0000_3000, 1, 1, 1, 1, 0);   // R7 both valid
        episode(32'h0000_4000, 0, 1, 1, 0, 0);   // R8 illegal outside decode
        episode(32'h0000_5000, 1, 0, 0, 1, 0);   // R8 overflow outside execute
        episode(32'h0000_6004, 0, 1, 0, 1, 1);   // R9 noise while busy
        // constrained random
        for (int i = 0; i < 600; i++) begin
            episode($urandom, 1'($urandom), 1'($urandom),
                    ($urandom % 3) == 0, ($urandom % 3) == 0, 1'($urandom));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 50000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule